// File: doc/BRIEF.md
# Four-Way DMA Request Arbiter with Switchable Policy

This block shares one bus master port among the four DMA clients of an Ethernet controller: the transmit descriptor engine, the transmit frame reader, the receive descriptor engine and the receive frame writer. At each arbitration point it picks one pending request and raises a one-hot grant. The grant is kept until the current owner pulses a burst-done signal, so a burst is never cut short.

Two policies are available. When the round-robin enable is clear and the link runs half duplex, the picker uses a fixed order. Receive beats transmit, and within a direction the descriptor client beats the frame client. When the round-robin enable is set, or the link runs full duplex, the picker rotates fairly among the clients. The policy inputs are read only at arbitration points, so a change made during a burst takes effect at the next handover. All logic runs on the single bus clock.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset the grant is all zero, busy is low and the rotation pointer selects index 0.
- R2: No more than one grant bit is ever high. If no request is pending at an arbitration point, the grant is zero in the following cycle.
- R3: When round_robin_en is 0 and full_duplex is 0, an arbitration point grants the pending request with the lowest index. The index map is bit 0 = receive descriptor, bit 1 = receive frame, bit 2 = transmit descriptor, bit 3 = transmit frame.
- R4: When round_robin_en is 1, an arbitration point grants the first pending index found by searching upward from the rotation pointer, wrapping from 3 to 0.
- R5: When full_duplex is 1, the round-robin rule of R4 applies whatever the value of round_robin_en.
- R6: While a grant is active and burst_done is low, the grant stays unchanged in the next cycle, whatever the requests do.
- R7: A change of round_robin_en or full_duplex during a burst leaves the grant unchanged. The new policy is used from the next arbitration point on.
- R8: Each new grant to index i moves the rotation pointer to (i+1) mod 4. This happens under both policies.
- R9: A burst_done pulse while no grant is active behaves like any other idle cycle. It neither clears the pointer nor moves it.
- R10: An arbitration point occurs when the grant is zero, or in the cycle burst_done is high. A pending request then produces a grant in the next cycle, so bursts can follow back to back with no idle gap.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_REQ | Request lines, index map as in R3 |
| burst_done | input | 1 | One-cycle pulse from the current owner ending its burst |
| round_robin_en | input | 1 | Configuration bit selecting rotation |
| full_duplex | input | 1 | Link duplex state; high forces rotation |
| grant | output | N_REQ | One-hot grant, zero when idle |
| busy | output | 1 | High while any grant is active |

## Verification
The main interaction is a burst ending in the same cycle that a new choice is made. The burst_done pulse releases the current owner, and in that same edge the next owner is picked under the policy and pointer in force at that moment. The bench provokes this by keeping several requests high through done pulses while it changes the policy inputs during and between bursts. Each cycle is judged against an arithmetic model of the pointer and the winning index. A second overlap is a done pulse that arrives with no owner. The bench checks that the following rotation still starts from the pointer that was there before.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   typedef enum logic {
      POL_FIXED = 1'b0,
      POL_ROUND = 1'b1
   } arb_policy_e;

   localparam int unsigned IDX_RX_DESC = 0;
   localparam int unsigned IDX_RX_DATA = 1;
   localparam int unsigned IDX_TX_DESC = 2;
   localparam int unsigned IDX_TX_DATA = 3;
   localparam int unsigned CLIENT_COUNT = 4;

   localparam int unsigned MAX_REQ = 16;

   function automatic arb_policy_e policy_of(input logic rr_bit, input logic fdx);
      return (rr_bit || fdx) ? POL_ROUND : POL_FIXED;
   endfunction

endpackage

// File: rtl/dma_arb_prio_pick.sv
module dma_arb_prio_pick #(
   parameter int unsigned N_REQ = 4,
   localparam int unsigned IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
   input  logic [N_REQ-1:0] req_i,
   output logic [N_REQ-1:0] oh_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);

   logic [N_REQ:0] seen;

   assign seen[0] = 1'b0;

   for (genvar gi = 0; gi < N_REQ; gi++) begin : g_chain
      assign seen[gi+1] = seen[gi] | req_i[gi];
      assign oh_o[gi]   = req_i[gi] & ~seen[gi];
   end

   assign any_o = seen[N_REQ];

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < int'(N_REQ); i++) begin
         if (oh_o[i]) idx_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/dma_arb_rr_pick.sv
module dma_arb_rr_pick #(
   parameter int unsigned N_REQ   = 4,
   parameter int unsigned RR_IMPL = 0,
   localparam int unsigned IDX_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
   input  logic [N_REQ-1:0] req_i,
   input  logic [IDX_W-1:0] ptr_i,
   output logic [N_REQ-1:0] oh_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);

   if (RR_IMPL == 0) begin : g_masked
      logic [N_REQ-1:0] upper_mask;
      logic [N_REQ-1:0] upper_req;
      logic [N_REQ-1:0] upper_oh, full_oh;
      logic [IDX_W-1:0] upper_idx, full_idx;
      logic             upper_any, full_any;

      for (genvar gi = 0; gi < N_REQ; gi++) begin : g_mask
         assign upper_mask[gi] = (IDX_W'(gi) >= ptr_i);
      end

      assign upper_req = req_i & upper_mask;

      dma_arb_prio_pick #(.N_REQ(N_REQ)) u_upper (
         .req_i (upper_req),
         .oh_o  (upper_oh),
         .idx_o (upper_idx),
         .any_o (upper_any)
      );

      dma_arb_prio_pick #(.N_REQ(N_REQ)) u_full (
         .req_i (req_i),
         .oh_o  (full_oh),
         .idx_o (full_idx),
         .any_o (full_any)
      );

      assign oh_o  = upper_any ? upper_oh  : full_oh;
      assign idx_o = upper_any ? upper_idx : full_idx;
      assign any_o = full_any;
   end else begin : g_scan
      always_comb begin
         int unsigned pos;
         logic        found;
         oh_o  = '0;
         idx_o = '0;
         found = 1'b0;
         pos   = 0;
         for (int k = 0; k < int'(N_REQ); k++) begin
            pos = (int'(ptr_i) + k) % N_REQ;
            if (!found && req_i[pos]) begin
               found     = 1'b1;
               oh_o[pos] = 1'b1;
               idx_o     = IDX_W'(pos);
            end
         end
         any_o = found;
      end
   end

endmodule

// File: rtl/dma_arb_grant_reg.sv
module dma_arb_grant_reg #(
   parameter int unsigned N_REQ  = 4,
   localparam int unsigned IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             burst_done_i,
   input  logic [N_REQ-1:0] pick_oh_i,
   input  logic [IDX_W-1:0] pick_idx_i,
   input  logic             pick_any_i,
   output logic [N_REQ-1:0] grant_o,
   output logic [IDX_W-1:0] ptr_o,
   output logic             arb_point_o
);

   logic [N_REQ-1:0] grant_q;
   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] ptr_next;

   assign arb_point_o = (grant_q == '0) || burst_done_i;

   always_comb begin
      if (pick_idx_i == IDX_W'(N_REQ - 1)) ptr_next = '0;
      else                                 ptr_next = pick_idx_i + IDX_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_q <= '0;
         ptr_q   <= '0;
      end else if (arb_point_o) begin
         grant_q <= pick_oh_i;
         if (pick_any_i) ptr_q <= ptr_next;
      end
   end

   assign grant_o = grant_q;
   assign ptr_o   = ptr_q;

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
   import dma_arb_pkg::*;
#(
   parameter int unsigned N_REQ   = 4,
   parameter int unsigned RR_IMPL = 0,
   localparam int unsigned IDX_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] req,
   input  logic             burst_done,
   input  logic             round_robin_en,
   input  logic             full_duplex,
   output logic [N_REQ-1:0] grant,
   output logic             busy
);

   if (N_REQ < 2 || N_REQ > MAX_REQ) begin : g_bad_count
      $error("dma_req_arbiter: N_REQ out of range");
   end
   if (RR_IMPL > 1) begin : g_bad_impl
      $error("dma_req_arbiter: RR_IMPL must be 0 or 1");
   end

   arb_policy_e      policy;
   logic [N_REQ-1:0] fx_oh, rr_oh, pick_oh;
   logic [IDX_W-1:0] fx_idx, rr_idx, pick_idx;
   logic             fx_any, rr_any, pick_any;
   logic [IDX_W-1:0] ptr;
   logic             arb_point;

   assign policy = policy_of(round_robin_en, full_duplex);

   dma_arb_prio_pick #(.N_REQ(N_REQ)) u_fixed (
      .req_i (req),
      .oh_o  (fx_oh),
      .idx_o (fx_idx),
      .any_o (fx_any)
   );

   dma_arb_rr_pick #(.N_REQ(N_REQ), .RR_IMPL(RR_IMPL)) u_rotate (
      .req_i (req),
      .ptr_i (ptr),
      .oh_o  (rr_oh),
      .idx_o (rr_idx),
      .any_o (rr_any)
   );

   always_comb begin
      if (policy == POL_ROUND) begin
         pick_oh  = rr_oh;
         pick_idx = rr_idx;
         pick_any = rr_any;
      end else begin
         pick_oh  = fx_oh;
         pick_idx = fx_idx;
         pick_any = fx_any;
      end
   end

   dma_arb_grant_reg #(.N_REQ(N_REQ)) u_hold (
      .clk          (clk),
      .rst_n        (rst_n),
      .burst_done_i (burst_done),
      .pick_oh_i    (pick_oh),
      .pick_idx_i   (pick_idx),
      .pick_any_i   (pick_any),
      .grant_o      (grant),
      .ptr_o        (ptr),
      .arb_point_o  (arb_point)
   );

   assign busy = |grant;

endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
   parameter int unsigned N_REQ = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_REQ-1:0] req,
   input logic             burst_done,
   input logic             round_robin_en,
   input logic             full_duplex,
   input logic [N_REQ-1:0] grant,
   input logic             busy
);

   assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_idle_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant == '0 || burst_done) && req == '0) |=> (grant == '0));

   assert_hold_until_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0 && !burst_done) |=> $stable(grant));

   assert_fixed_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant == '0 || burst_done) && !round_robin_en && !full_duplex && req != '0)
      |=> (grant != '0 && ((grant - N_REQ'(1)) & $past(req)) == '0));

   assert_grant_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant == '0 || burst_done) && req != '0) |=> (grant != '0 && (grant & $past(req)) != '0));

   assert_busy_tracks_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (grant != '0));

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.N_REQ(N_REQ)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req            (req),
   .burst_done     (burst_done),
   .round_robin_en (round_robin_en),
   .full_duplex    (full_duplex),
   .grant          (grant),
   .busy           (busy)
);

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb;

   localparam int CLK_PERIOD = 10;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic         burst_done = 1'b0;
   logic         round_robin_en = 1'b0;
   logic         full_duplex = 1'b0;
   logic [N-1:0] grant;
   logic         busy;

   int checks = 0;
   int errors = 0;
   int eg = -1;
   int ep = 0;
   logic prev_rr = 1'b0;
   logic prev_fd = 1'b0;
   logic [31:0] lfsr = 32'hACE1_2468;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_req_arbiter #(.N_REQ(N)) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .req            (req),
      .burst_done     (burst_done),
      .round_robin_en (round_robin_en),
      .full_duplex    (full_duplex),
      .grant          (grant),
      .busy           (busy)
   );

   function automatic logic [N-1:0] exp_vec(input int g);
      return (g < 0) ? '0 : (N'(1) << g);
   endfunction

   task automatic check_out(input string tag);
      logic [N-1:0] e;
      e = exp_vec(eg);
      checks++;
      if (grant !== e || busy !== (eg >= 0)) begin
         errors++;
         $display("FAIL %s: grant=%b busy=%b expected grant=%b busy=%b",
                  tag, grant, busy, e, (eg >= 0));
      end
   endtask

   task automatic cyc(input logic [N-1:0] r, input logic d, input logic rr,
                      input logic fd, input string tag_in);
      string tag;
      bit was_idle;
      tag = "R6";
      was_idle = (eg < 0);
      req = r; burst_done = d; round_robin_en = rr; full_duplex = fd;
      if (eg < 0 || d) begin
         if (r == '0) begin
            eg  = -1;
            tag = (d && was_idle) ? "R9" : "R2";
         end else if (rr || fd) begin
            for (int k = 0; k < N; k++) begin
               int p;
               p = (ep + k) % N;
               if (r[p]) begin eg = p; break; end
            end
            tag = rr ? "R4" : "R5";
            ep = (eg + 1) % N;
         end else begin
            for (int k = N - 1; k >= 0; k--) if (r[k]) eg = k;
            tag = "R3";
            ep = (eg + 1) % N;
         end
      end else if (rr != prev_rr || fd != prev_fd) begin
         tag = "R7";
      end
      prev_rr = rr; prev_fd = fd;
      if (tag_in != "") tag = tag_in;
      @(posedge clk);
      @(negedge clk);
      check_out(tag);
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_out("R1");
      rst_n = 1'b1;

      // R8: rotation walks 0,1,2,3,0 with every request high
      cyc(4'b1111, 1'b0, 1'b1, 1'b0, "R8");
      for (int i = 0; i < 4; i++) cyc(4'b1111, 1'b1, 1'b1, 1'b0, "R8");
      cyc(4'b0000, 1'b1, 1'b1, 1'b0, "R2");

      // R9: done while idle leaves the pointer alone
      cyc(4'b0000, 1'b1, 1'b1, 1'b0, "R9");
      cyc(4'b0000, 1'b1, 1'b1, 1'b0, "R9");
      cyc(4'b1111, 1'b0, 1'b1, 1'b0, "R9");
      cyc(4'b0000, 1'b1, 1'b0, 1'b0, "R2");

      // R7: policy flips during a fixed-priority burst
      cyc(4'b1010, 1'b0, 1'b0, 1'b0, "R3");
      cyc(4'b1111, 1'b0, 1'b1, 1'b0, "R7");
      cyc(4'b1111, 1'b0, 1'b0, 1'b1, "R7");
      cyc(4'b1111, 1'b1, 1'b0, 1'b1, "R5");

      // R10: back-to-back handover under fixed priority
      cyc(4'b1100, 1'b1, 1'b0, 1'b0, "R10");
      cyc(4'b1000, 1'b1, 1'b0, 1'b0, "R10");
      cyc(4'b0000, 1'b1, 1'b0, 1'b0, "R2");

      // sweep: every request pattern under every policy pair, from idle
      for (int m = 0; m < 4; m++) begin
         for (int r = 0; r < 16; r++) begin
            cyc(N'(r), 1'b0, m[0], m[1], "");
            cyc(N'(r), 1'b0, m[0], m[1], "");
            cyc(4'b0000, 1'b1, m[0], m[1], "");
         end
      end

      // long pseudo-random run with done pulses and policy changes
      for (int i = 0; i < 4000; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         cyc(lfsr[3:0], (lfsr[6:5] == 2'b00), lfsr[12], lfsr[13] & lfsr[14], "");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule